// File: doc/BRIEF.md
# Prefixed Shift, Rotate and Bit Execution Unit

This unit executes the second byte of a two-byte prefixed instruction class on an 8-bit datapath. Each cycle it may accept one opcode byte together with the operand value and the current flag state. One clock later it presents the computed byte, the four updated condition flags, a write-back enable and the register code for the destination. Fetching the operand from a register file or memory, and writing the result back, are left to the surrounding core.

The opcode byte holds three fields. Bits 7:6 pick the group. Bits 5:3 give either the shift/rotate kind or a bit index. Bits 2:0 give the operand register code, which is passed through untouched. The shift group covers two plain rotates, two rotates through the carry, a left shift, a logical and an arithmetic right shift, and a nibble swap. The other three groups test, clear or set one indexed bit.

Top module: `pfx_exec_unit`

## Requirements
- R1: While `rst` is high at a clock edge, every output is driven to 0 after that edge.
- R2: `out_valid` equals the `in_valid` of the previous cycle. `out_wr_en` is 0 whenever `out_valid` is 0.
- R3: With opcode bits 7:6 = 0: kind 0 (bits 5:3) rotates left, so bit 7 goes to bit 0 and to carry; kind 1 rotates right, so bit 0 goes to bit 7 and to carry.
- R4: Kind 2 rotates left with the old carry entering bit 0 and bit 7 leaving to carry. Kind 3 rotates right with the old carry entering bit 7 and bit 0 leaving to carry.
- R5: Kind 4 shifts left with a 0 into bit 0 and bit 7 to carry. Kind 7 shifts right with a 0 into bit 7 and bit 0 to carry.
- R6: Kind 5 shifts right keeping bit 7 as it was, with bit 0 to carry.
- R7: Kind 6 exchanges bits 7:4 with bits 3:0 and clears carry.
- R8: Every shift-group operation asserts write-back, sets Z exactly when the result is 0, and clears N and H.
- R9: Opcode bits 7:6 = 1 tests the bit indexed by bits 5:3. It does not write back, and the result equals the operand. Z becomes the inverse of the tested bit, N=0, H=1, and C is unchanged from `in_carry`.
- R10: Opcode bits 7:6 = 2 clears and 3 sets the indexed bit. Write-back is asserted and all four flags pass through from their inputs.
- R11: `out_reg_sel` equals bits 2:0 of the opcode accepted one cycle earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Opcode and operand present this cycle |
| in_opcode | input | 8 | Prefixed opcode byte |
| in_operand | input | DW | Operand value |
| in_carry | input | 1 | Current carry flag |
| in_flag_z | input | 1 | Current zero flag |
| in_flag_n | input | 1 | Current subtract flag |
| in_flag_h | input | 1 | Current half-carry flag |
| out_valid | output | 1 | Result registered from last cycle's accepted op |
| out_result | output | DW | Computed byte |
| out_wr_en | output | 1 | Result should be written back |
| out_reg_sel | output | 3 | Operand register code |
| out_flag_z | output | 1 | Updated zero flag |
| out_flag_n | output | 1 | Updated subtract flag |
| out_flag_h | output | 1 | Updated half-carry flag |
| out_flag_c | output | 1 | Updated carry flag |

## Verification
Every result, flag, write-back enable and register code is due exactly one clock edge after the cycle in which its opcode was presented, since one output register lies on each path. The bench drives a new vector on each falling edge and compares all outputs 1 ns after the next rising edge. This is the first moment that vector's outputs are settled, and it comes before the following vector is driven. Idle cycles are checked on the same one-edge schedule to show that `out_valid` and `out_wr_en` drop. All 256 opcodes are swept against every operand and both carry values, followed by seeded random vectors.

// File: rtl/pfx_pkg.sv
package pfx_pkg;

  typedef enum logic [1:0] {
    GRP_SHIFT = 2'd0,
    GRP_TEST  = 2'd1,
    GRP_CLR   = 2'd2,
    GRP_SET   = 2'd3
  } grp_e;

  typedef enum logic [2:0] {
    K_ROT_L8   = 3'd0,
    K_ROT_R8   = 3'd1,
    K_ROT_L9   = 3'd2,
    K_ROT_R9   = 3'd3,
    K_SHL      = 3'd4,
    K_ASR      = 3'd5,
    K_NIB_SWAP = 3'd6,
    K_LSR      = 3'd7
  } kind_e;

  typedef struct packed {
    grp_e       grp;
    kind_e      kind;
    logic [2:0] idx;
    logic [2:0] rsel;
  } dec_t;

  typedef struct packed {
    logic z;
    logic n;
    logic h;
    logic c;
  } flags_t;

endpackage

// File: rtl/pfx_decode.sv
module pfx_decode
  import pfx_pkg::*;
(
  input  logic [7:0] opcode,
  output dec_t       dec
);
  always_comb begin
    dec.grp  = grp_e'(opcode[7:6]);
    dec.kind = kind_e'(opcode[5:3]);
    dec.idx  = opcode[5:3];
    dec.rsel = opcode[2:0];
  end
endmodule

// File: rtl/pfx_shift_unit.sv
module pfx_shift_unit
  import pfx_pkg::*;
#(
  parameter int DW = 8
) (
  input  kind_e         kind,
  input  logic [DW-1:0] a,
  input  logic          cin,
  output logic [DW-1:0] res,
  output logic          cout
);
  localparam int HALF = DW / 2;

  always_comb begin
    res  = a;
    cout = 1'b0;
    unique case (kind)
      K_ROT_L8:   begin res = {a[DW-2:0], a[DW-1]}; cout = a[DW-1]; end
      K_ROT_R8:   begin res = {a[0], a[DW-1:1]};    cout = a[0];    end
      K_ROT_L9:   begin res = {a[DW-2:0], cin};     cout = a[DW-1]; end
      K_ROT_R9:   begin res = {cin, a[DW-1:1]};     cout = a[0];    end
      K_SHL:      begin res = {a[DW-2:0], 1'b0};    cout = a[DW-1]; end
      K_ASR:      begin res = {a[DW-1], a[DW-1:1]}; cout = a[0];    end
      K_NIB_SWAP: begin res = {a[HALF-1:0], a[DW-1:HALF]}; cout = 1'b0; end
      K_LSR:      begin res = {1'b0, a[DW-1:1]};    cout = a[0];    end
      default:    begin res = a; cout = 1'b0; end
    endcase
  end

  // Swap and plain rotates only rearrange bits: population is preserved (R7, R3)
  always_comb begin
    if (kind == K_NIB_SWAP || kind == K_ROT_L8 || kind == K_ROT_R8)
      assert_bits_preserved_R7: assert ($countones(res) == $countones(a));
  end
endmodule

// File: rtl/pfx_bit_unit.sv
module pfx_bit_unit
  import pfx_pkg::*;
#(
  parameter int DW = 8
) (
  input  grp_e          grp,
  input  logic [2:0]    idx,
  input  logic [DW-1:0] a,
  output logic [DW-1:0] res,
  output logic          bit_val
);
  localparam int IW = $clog2(DW);

  logic [IW-1:0] sel;
  assign sel = idx[IW-1:0];

  always_comb begin
    res     = a;
    bit_val = a[sel];
    if (grp == GRP_CLR) res[sel] = 1'b0;
    if (grp == GRP_SET) res[sel] = 1'b1;
  end

  // Clear/set touch exactly one bit position (R10)
  always_comb begin
    if (grp == GRP_CLR || grp == GRP_SET)
      assert_single_bit_touch_R10: assert ($countones(res ^ a) <= 1);
  end
endmodule

// File: rtl/pfx_exec_unit.sv
module pfx_exec_unit
  import pfx_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic [7:0]    in_opcode,
  input  logic [DW-1:0] in_operand,
  input  logic          in_carry,
  input  logic          in_flag_z,
  input  logic          in_flag_n,
  input  logic          in_flag_h,
  output logic          out_valid,
  output logic [DW-1:0] out_result,
  output logic          out_wr_en,
  output logic [2:0]    out_reg_sel,
  output logic          out_flag_z,
  output logic          out_flag_n,
  output logic          out_flag_h,
  output logic          out_flag_c
);
  dec_t          dec;
  logic [DW-1:0] sh_res;
  logic          sh_cout;
  logic [DW-1:0] bt_res;
  logic          bt_val;
  logic [DW-1:0] nx_res;
  logic          nx_wr;
  flags_t        nx_fl;
  flags_t        fl_in;

  assign fl_in = '{z: in_flag_z, n: in_flag_n, h: in_flag_h, c: in_carry};

  pfx_decode u_dec (
    .opcode (in_opcode),
    .dec    (dec)
  );

  pfx_shift_unit #(.DW(DW)) u_shift (
    .kind (dec.kind),
    .a    (in_operand),
    .cin  (in_carry),
    .res  (sh_res),
    .cout (sh_cout)
  );

  pfx_bit_unit #(.DW(DW)) u_bit (
    .grp     (dec.grp),
    .idx     (dec.idx),
    .a       (in_operand),
    .res     (bt_res),
    .bit_val (bt_val)
  );

  always_comb begin
    nx_res = in_operand;
    nx_wr  = 1'b0;
    nx_fl  = fl_in;
    unique case (dec.grp)
      GRP_SHIFT: begin
        nx_res = sh_res;
        nx_wr  = 1'b1;
        nx_fl  = '{z: (sh_res == '0), n: 1'b0, h: 1'b0, c: sh_cout};
      end
      GRP_TEST: begin
        nx_res = in_operand;
        nx_wr  = 1'b0;
        nx_fl  = '{z: ~bt_val, n: 1'b0, h: 1'b1, c: in_carry};
      end
      default: begin
        nx_res = bt_res;
        nx_wr  = 1'b1;
        nx_fl  = fl_in;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid   <= 1'b0;
      out_result  <= '0;
      out_wr_en   <= 1'b0;
      out_reg_sel <= '0;
      out_flag_z  <= 1'b0;
      out_flag_n  <= 1'b0;
      out_flag_h  <= 1'b0;
      out_flag_c  <= 1'b0;
    end else begin
      out_valid <= in_valid;
      out_wr_en <= in_valid & nx_wr;
      if (in_valid) begin
        out_result  <= nx_res;
        out_reg_sel <= dec.rsel;
        out_flag_z  <= nx_fl.z;
        out_flag_n  <= nx_fl.n;
        out_flag_h  <= nx_fl.h;
        out_flag_c  <= nx_fl.c;
      end
    end
  end

  assert_valid_follows_R2: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> out_valid == $past(in_valid));

  assert_no_idle_write_R2: assert property (@(posedge clk) disable iff (rst)
    out_wr_en |-> out_valid);

  assert_shift_flags_R8: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(in_valid) && $past(in_opcode[7:6]) == 2'd0)
      |-> (out_wr_en && !out_flag_n && !out_flag_h
           && out_flag_z == (out_result == '0)));

  assert_test_no_write_R9: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(in_valid) && $past(in_opcode[7:6]) == 2'd1)
      |-> (!out_wr_en && out_flag_h && !out_flag_n
           && out_flag_c == $past(in_carry) && out_result == $past(in_operand)));

  assert_flags_pass_R10: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(in_valid) && $past(in_opcode[7]))
      |-> (out_wr_en && out_flag_z == $past(in_flag_z) && out_flag_n == $past(in_flag_n)
           && out_flag_h == $past(in_flag_h) && out_flag_c == $past(in_carry)));

  assert_reg_code_R11: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(in_valid)) |-> out_reg_sel == $past(in_opcode[2:0]));

endmodule

// File: tb/test_pfx_exec_unit.sv
module test_pfx_exec_unit;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       in_valid = 1'b0;
  logic [7:0] in_opcode = '0;
  logic [7:0] in_operand = '0;
  logic       in_carry = 1'b0;
  logic       in_flag_z = 1'b0;
  logic       in_flag_n = 1'b0;
  logic       in_flag_h = 1'b0;
  logic       out_valid;
  logic [7:0] out_result;
  logic       out_wr_en;
  logic [2:0] out_reg_sel;
  logic       out_flag_z, out_flag_n, out_flag_h, out_flag_c;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #5 clk = ~clk;

  pfx_exec_unit #(.DW(8)) i_pfx_exec_unit (
    .clk, .rst, .in_valid, .in_opcode, .in_operand, .in_carry,
    .in_flag_z, .in_flag_n, .in_flag_h,
    .out_valid, .out_result, .out_wr_en, .out_reg_sel,
    .out_flag_z, .out_flag_n, .out_flag_h, .out_flag_c
  );

  // {result[7:0], wr, z, n, h, c}
  function automatic logic [12:0] model(input logic [7:0] op, input logic [7:0] a,
                                        input logic c, input logic z, input logic n,
                                        input logic h);
    logic [7:0] r;
    logic co, wz, wn, wh, wc, wr;
    r = a; co = 1'b0; wz = z; wn = n; wh = h; wc = c; wr = 1'b0;
    case (op[7:6])
      2'd0: begin
        case (op[5:3])
          3'd0: begin co = a[7]; r = {a[6:0], a[7]}; end
          3'd1: begin co = a[0]; r = {a[0], a[7:1]}; end
          3'd2: begin co = a[7]; r = {a[6:0], c}; end
          3'd3: begin co = a[0]; r = {c, a[7:1]}; end
          3'd4: begin co = a[7]; r = {a[6:0], 1'b0}; end
          3'd5: begin co = a[0]; r = {a[7], a[7:1]}; end
          3'd6: begin co = 1'b0; r = {a[3:0], a[7:4]}; end
          default: begin co = a[0]; r = {1'b0, a[7:1]}; end
        endcase
        wz = (r == 8'd0); wn = 1'b0; wh = 1'b0; wc = co; wr = 1'b1;
      end
      2'd1: begin wz = ~a[op[5:3]]; wn = 1'b0; wh = 1'b1; end
      2'd2: begin r[op[5:3]] = 1'b0; wr = 1'b1; end
      default: begin r[op[5:3]] = 1'b1; wr = 1'b1; end
    endcase
    return {r, wr, wz, wn, wh, wc};
  endfunction

  function automatic string tag_of(input logic [7:0] op);
    if (op[7:6] == 2'd1) return "R9";
    if (op[7:6] != 2'd0) return "R10";
    case (op[5:3])
      3'd0, 3'd1: return "R3,R8";
      3'd2, 3'd3: return "R4,R8";
      3'd4, 3'd7: return "R5,R8";
      3'd5:       return "R6,R8";
      default:    return "R7,R8";
    endcase
  endfunction

  // Drive at falling edge, sample 1 ns after the next rising edge (one register).
  task automatic run_vec(input logic [7:0] op, input logic [7:0] a, input logic c,
                         input logic z, input logic n, input logic h);
    logic [12:0] exp_v, act_v;
    in_valid = 1'b1; in_opcode = op; in_operand = a;
    in_carry = c; in_flag_z = z; in_flag_n = n; in_flag_h = h;
    @(posedge clk); #1;
    exp_v = model(op, a, c, z, n, h);
    act_v = {out_result, out_wr_en, out_flag_z, out_flag_n, out_flag_h, out_flag_c};
    n_checks++;
    if (act_v !== exp_v || out_valid !== 1'b1) begin
      n_fail++;
      $display("FAIL %s op=%02h a=%02h c=%0b: actual %h valid=%0b expected %h valid=1",
               tag_of(op), op, a, c, act_v, out_valid, exp_v);
    end
    n_checks++;
    if (out_reg_sel !== op[2:0]) begin
      n_fail++;
      $display("FAIL R11 op=%02h: actual %0d expected %0d", op, out_reg_sel, op[2:0]);
    end
    @(negedge clk);
  endtask

  task automatic idle_check;
    in_valid = 1'b0;
    in_opcode = 8'h00;
    @(posedge clk); #1;
    n_checks++;
    if (out_valid !== 1'b0 || out_wr_en !== 1'b0) begin
      n_fail++;
      $display("FAIL R2 idle: actual valid=%0b wr=%0b expected valid=0 wr=0",
               out_valid, out_wr_en);
    end
    @(negedge clk);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    in_valid = 1'b1;
    in_opcode = 8'hFF;
    in_operand = 8'hFF;
    repeat (3) @(posedge clk);
    #1;
    n_checks++;  // R1 reset state
    if ({out_valid, out_result, out_wr_en, out_reg_sel, out_flag_z, out_flag_n,
         out_flag_h, out_flag_c} !== '0) begin
      n_fail++;
      $display("FAIL R1 reset: actual valid=%0b res=%02h wr=%0b expected all 0",
               out_valid, out_result, out_wr_en);
    end
    @(negedge clk);
    rst = 1'b0;
    in_valid = 1'b0;
    idle_check();

    // directed corners
    run_vec(8'h00, 8'h80, 1'b0, 1'b0, 1'b1, 1'b1);  // R3 rotate left wraps
    run_vec(8'h08, 8'h01, 1'b0, 1'b0, 1'b0, 1'b0);  // R3 rotate right wraps
    run_vec(8'h10, 8'h80, 1'b0, 1'b0, 1'b0, 1'b0);  // R4 result zero via carry
    run_vec(8'h18, 8'h00, 1'b1, 1'b1, 1'b0, 1'b0);  // R4 carry into bit 7
    run_vec(8'h20, 8'h80, 1'b0, 1'b0, 1'b0, 1'b0);  // R5 shift to zero
    run_vec(8'h28, 8'h81, 1'b0, 1'b0, 1'b0, 1'b0);  // R6 sign kept
    run_vec(8'h30, 8'hA5, 1'b1, 1'b0, 1'b0, 1'b0);  // R7 carry cleared
    run_vec(8'h38, 8'h01, 1'b0, 1'b0, 1'b0, 1'b0);  // R5 logical right to zero
    run_vec(8'h7E, 8'h7F, 1'b1, 1'b0, 1'b1, 1'b0);  // R9 bit 7 clear
    run_vec(8'h86, 8'h01, 1'b1, 1'b1, 1'b1, 1'b1);  // R10 clear bit 0
    run_vec(8'hFF, 8'h00, 1'b0, 1'b1, 1'b0, 1'b1);  // R10 set bit 7
    idle_check();  // R2 gap mid stream
    run_vec(8'h47, 8'h01, 1'b0, 1'b0, 1'b0, 1'b0);  // R9 bit 0 set

    // exhaustive sweep
    for (int op = 0; op < 256; op++) begin
      for (int a = 0; a < 256; a++) begin
        for (int c = 0; c < 2; c++) begin
          logic [2:0] r3;
          r3 = 3'($urandom);
          run_vec(8'(op), 8'(a), 1'(c), r3[0], r3[1], r3[2]);
        end
      end
    end

    // seeded random with occasional idle gaps
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] rv;
      rv = $urandom;
      if (rv[31:28] == 4'd0) idle_check();
      else run_vec(rv[7:0], rv[15:8], rv[16], rv[17], rv[18], rv[19]);
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule